// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder and Data-Path Selector

This block sits behind an external TAP controller. It receives the controller's capture, shift and update strobes for both the instruction path and the data path. It holds a 4-bit instruction register and decodes the active instruction. That instruction sets two things at once: which data register is placed between `tdi` and `tdo`, and how the boundary cells behave. The cells sit between the core and the pins.

The decoded instruction forms a small state set of five paths: PATH_BYPASS, PATH_SAMPLE, PATH_EXTEST, PATH_IDCODE and PATH_USER. Three transitions change the state:

- An asynchronous `trst_n` assertion moves to PATH_IDCODE.
- A cycle with `tap_reset` high (the controller is in its reset state) moves to PATH_IDCODE.
- An instruction-update strobe moves to whatever path the shifted code decodes to. Any code without a defined meaning falls to PATH_BYPASS.

No other event changes the path.

The boundary register has `N_OUT` output cells and `N_IN` input cells. Only the output cells carry an update stage. That stage is loaded under SAMPLE/PRELOAD and driven onto the pins under EXTEST. Because the stage is never cleared by an instruction change, a preloaded pattern is exactly what EXTEST drives. Shifting always moves bits from `tdi` into the top bit of the selected register, toward bit 0, and bit 0 is presented on `tdo` on the falling edge.

Top module: `jtag_insn_sel`

## Requirements
- R1: On an instruction-capture strobe the instruction shift register loads binary 0001, so the first four bits shifted out on `tdo` are 1, 0, 0, 0.
- R2: After `trst_n` or a cycle with `tap_reset` high, the active instruction is IDCODE (0010). A data scan then returns the 32-bit identification value, least significant bit first, and that bit is always 1.
- R3: The active instruction changes only on an instruction-update strobe (or reset). Shifting a new code without update leaves the pins and the selected path unchanged.
- R4: Code 1111 (BYPASS) and every code other than 0000, 0001, 0010 and 1000 select a one-bit register. That register captures 0 and delays `tdi` by exactly one shift.
- R5: SAMPLE/PRELOAD (0001) selects the boundary register. Its capture layout is as follows: bits [N_OUT-1:0] take the current `pin_out` values and bits [N_OUT+N_IN-1:N_OUT] take `pin_in`. Meanwhile `pin_out` follows `core_out`. A data update copies bits [N_OUT-1:0] into the update stage without driving the pins.
- R6: EXTEST (0000) selects the boundary register with the same capture layout and drives `pin_out` from the update stage. A data update under EXTEST changes the driven pattern.
- R7: The update stage resets to `OUT_RST` on `trst_n` only. It keeps its value across instruction changes and `tap_reset`, and is written only by a data update under SAMPLE/PRELOAD or EXTEST. Entering EXTEST straight after reset therefore drives `OUT_RST`.
- R8: USER (1000) selects a `USER_W`-bit register that captures `user_status`; a data update copies it to `user_ctrl`. `user_ctrl` changes at no other time except reset to 0.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only after a falling edge during which a shift strobe was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_reset | input | 1 | High while the TAP controller is in its reset state |
| ir_capture | input | 1 | Instruction-path capture strobe |
| ir_shift | input | 1 | Instruction-path shift strobe |
| ir_update | input | 1 | Instruction-path update strobe |
| dr_capture | input | 1 | Data-path capture strobe |
| dr_shift | input | 1 | Data-path shift strobe |
| dr_update | input | 1 | Data-path update strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| core_out | input | N_OUT | Functional values from the core toward the pins |
| pin_out | output | N_OUT | Values driven onto the output pins |
| pin_in | input | N_IN | Values present on the input pins |
| core_in | output | N_IN | Input pin values passed to the core |
| user_status | input | USER_W | Parallel value captured by the user register |
| user_ctrl | output | USER_W | Parallel value written by the user register |

## Verification
The bench loads all sixteen instruction codes in turn and scans a 40-bit data stream under each. It checks the captured prefix, the shift length and the residual `tdi` delay, so a decoder that left an undefined code on the boundary or user path, or gave BYPASS a capture of 1, shows a length or content mismatch. A dedicated sequence preloads a pattern under SAMPLE/PRELOAD and then enters EXTEST. It also enters EXTEST straight after reset and again after `tap_reset`. A design that cleared the update stage on an instruction change, or on the controller reset, would drive zeros instead of the preload or `OUT_RST`. Shifting the EXTEST code without an update pulse catches a design that lets the shift stage reach the decoder early. A sample taken just after each rising edge catches a `tdo` that moves on the wrong edge.

// File: rtl/jtsel_pkg.sv
`timescale 1ns/1ps
package jtsel_pkg;

    localparam int unsigned OP_W = 4;
    typedef logic [OP_W-1:0] op_t;

    // instruction encodings
    localparam op_t OP_EXTEST  = 4'b0000;
    localparam op_t OP_SAMPLE  = 4'b0001;
    localparam op_t OP_IDCODE  = 4'b0010;
    localparam op_t OP_USER    = 4'b1000;
    localparam op_t OP_BYPASS  = 4'b1111;
    // pattern loaded into the instruction shift stage on capture
    localparam op_t OP_CAPTURE = 4'b0001;

    typedef enum logic [2:0] {
        PATH_BYPASS,
        PATH_SAMPLE,
        PATH_EXTEST,
        PATH_IDCODE,
        PATH_USER
    } path_e;

    function automatic path_e decode_op(input op_t op);
        path_e p;
        unique case (op)
            OP_EXTEST: p = PATH_EXTEST;
            OP_SAMPLE: p = PATH_SAMPLE;
            OP_IDCODE: p = PATH_IDCODE;
            OP_USER:   p = PATH_USER;
            default:   p = PATH_BYPASS;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/jtsel_ir.sv
`timescale 1ns/1ps
module jtsel_ir
    import jtsel_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tap_reset,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output op_t  ir_q,
    output logic so
);

    op_t sh_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= OP_CAPTURE;
            ir_q <= OP_IDCODE;
        end else begin
            if (capture) begin
                sh_q <= OP_CAPTURE;
            end else if (shift) begin
                sh_q <= {tdi, sh_q[OP_W-1:1]};
            end
            if (tap_reset) begin
                ir_q <= OP_IDCODE;
            end else if (update) begin
                ir_q <= sh_q;
            end
        end
    end

    assign so = sh_q[0];

endmodule

// File: rtl/jtsel_bsr.sv
`timescale 1ns/1ps
module jtsel_bsr #(
    parameter int unsigned     N_OUT   = 4,
    parameter int unsigned     N_IN    = 4,
    parameter logic [N_OUT-1:0] OUT_RST = '0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    input  logic [N_OUT-1:0] pins_out_now,
    input  logic [N_IN-1:0]  pins_in,
    output logic             so,
    output logic [N_OUT-1:0] upd_q
);

    localparam int unsigned W = N_OUT + N_IN;

    logic [W-1:0] sh_q;

    // capture/shift stage: output cells low, input cells high
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '0;
        end else if (capture) begin
            sh_q <= {pins_in, pins_out_now};
        end else if (shift) begin
            sh_q <= {tdi, sh_q[W-1:1]};
        end
    end

    // update stage of the output cells; never cleared by an instruction change
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_q <= OUT_RST;
        end else if (update) begin
            upd_q <= sh_q[N_OUT-1:0];
        end
    end

    assign so = sh_q[0];

endmodule

// File: rtl/jtsel_udr.sv
`timescale 1ns/1ps
module jtsel_udr #(
    parameter int unsigned W = 8
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         tdi,
    input  logic [W-1:0] status,
    output logic         so,
    output logic [W-1:0] ctrl
);

    logic [W-1:0] sh_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '0;
            ctrl <= '0;
        end else begin
            if (capture) begin
                sh_q <= status;
            end else if (shift) begin
                sh_q <= {tdi, sh_q[W-1:1]};
            end
            if (update) begin
                ctrl <= sh_q;
            end
        end
    end

    assign so = sh_q[0];

endmodule

// File: rtl/jtag_insn_sel.sv
`timescale 1ns/1ps
module jtag_insn_sel
    import jtsel_pkg::*;
#(
    parameter int unsigned      N_OUT   = 4,
    parameter int unsigned      N_IN    = 4,
    parameter int unsigned      USER_W  = 8,
    parameter logic [31:0]      ID_CODE = 32'h4D2A_61C3,
    parameter logic [N_OUT-1:0] OUT_RST = '0
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tap_reset,
    input  logic              ir_capture,
    input  logic              ir_shift,
    input  logic              ir_update,
    input  logic              dr_capture,
    input  logic              dr_shift,
    input  logic              dr_update,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [N_OUT-1:0]  core_out,
    output logic [N_OUT-1:0]  pin_out,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_IN-1:0]   core_in,
    input  logic [USER_W-1:0] user_status,
    output logic [USER_W-1:0] user_ctrl
);

    localparam int unsigned     ID_W   = 32;
    localparam logic [ID_W-1:0] ID_VAL = {ID_CODE[ID_W-1:1], 1'b1};

    op_t        ir_q;
    logic       ir_so;
    path_e      path;
    logic       sel_byp, sel_bsr, sel_id, sel_usr, drive_pins;
    logic       byp_q;
    logic [ID_W-1:0] id_sh;
    logic       bsr_so, usr_so, dr_so;
    logic [N_OUT-1:0] bsr_upd;
    logic       tdo_q, oe_q;

    jtsel_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .tap_reset (tap_reset),
        .capture   (ir_capture),
        .shift     (ir_shift),
        .update    (ir_update),
        .tdi       (tdi),
        .ir_q      (ir_q),
        .so        (ir_so)
    );

    // path state follows the held instruction
    assign path = decode_op(ir_q);

    // per-path outputs
    always_comb begin
        sel_byp    = 1'b0;
        sel_bsr    = 1'b0;
        sel_id     = 1'b0;
        sel_usr    = 1'b0;
        drive_pins = 1'b0;
        unique case (path)
            PATH_BYPASS: sel_byp = 1'b1;
            PATH_SAMPLE: sel_bsr = 1'b1;
            PATH_EXTEST: begin
                sel_bsr    = 1'b1;
                drive_pins = 1'b1;
            end
            PATH_IDCODE: sel_id  = 1'b1;
            PATH_USER:   sel_usr = 1'b1;
            default:     sel_byp = 1'b1;
        endcase
    end

    // one-bit bypass register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (dr_capture && sel_byp) begin
            byp_q <= 1'b0;
        end else if (dr_shift && sel_byp) begin
            byp_q <= tdi;
        end
    end

    // identification register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_sh <= ID_VAL;
        end else if (dr_capture && sel_id) begin
            id_sh <= ID_VAL;
        end else if (dr_shift && sel_id) begin
            id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    jtsel_bsr #(
        .N_OUT   (N_OUT),
        .N_IN    (N_IN),
        .OUT_RST (OUT_RST)
    ) u_bsr (
        .tck          (tck),
        .trst_n       (trst_n),
        .capture      (dr_capture && sel_bsr),
        .shift        (dr_shift && sel_bsr),
        .update       (dr_update && sel_bsr),
        .tdi          (tdi),
        .pins_out_now (pin_out),
        .pins_in      (pin_in),
        .so           (bsr_so),
        .upd_q        (bsr_upd)
    );

    jtsel_udr #(
        .W (USER_W)
    ) u_udr (
        .tck     (tck),
        .trst_n  (trst_n),
        .capture (dr_capture && sel_usr),
        .shift   (dr_shift && sel_usr),
        .update  (dr_update && sel_usr),
        .tdi     (tdi),
        .status  (user_status),
        .so      (usr_so),
        .ctrl    (user_ctrl)
    );

    // output-cell pin multiplexers
    for (genvar g = 0; g < int'(N_OUT); g++) begin : g_ocell
        assign pin_out[g] = drive_pins ? bsr_upd[g] : core_out[g];
    end

    assign core_in = pin_in;

    // serial data-path selection
    always_comb begin
        unique case (path)
            PATH_SAMPLE, PATH_EXTEST: dr_so = bsr_so;
            PATH_IDCODE:              dr_so = id_sh[0];
            PATH_USER:                dr_so = usr_so;
            default:                  dr_so = byp_q;
        endcase
    end

    // falling-edge retiming of the serial output
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= ir_shift || dr_shift;
            if (ir_shift) begin
                tdo_q <= ir_so;
            end else if (dr_shift) begin
                tdo_q <= dr_so;
            end
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/jtsel_chk.sv
`timescale 1ns/1ps
module jtsel_chk
    import jtsel_pkg::*;
#(
    parameter int unsigned N_OUT = 4
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tap_reset,
    input logic             ir_capture,
    input logic             ir_shift,
    input logic             ir_update,
    input logic             dr_capture,
    input logic             dr_shift,
    input logic             dr_update,
    input op_t              ir_q,
    input logic             ir_so,
    input logic             byp_q,
    input logic [N_OUT-1:0] bsr_upd,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_OUT-1:0] core_out,
    input logic             tdo_oe
);

    // R1
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ir_capture |=> ir_so);

    // R2
    tap_reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tap_reset |=> (ir_q == OP_IDCODE));

    // R3
    ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!ir_update && !tap_reset) |=> $stable(ir_q));

    // R4
    bypass_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (dr_capture && ir_q != OP_EXTEST && ir_q != OP_SAMPLE &&
         ir_q != OP_IDCODE && ir_q != OP_USER) |=> !byp_q);

    // R5
    sample_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == OP_SAMPLE) |-> (pin_out == core_out));

    // R6
    extest_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (ir_q == OP_EXTEST) |-> (pin_out == bsr_upd));

    // R7
    update_stage_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(dr_update && (ir_q == OP_EXTEST || ir_q == OP_SAMPLE)) |=> $stable(bsr_upd));

    // R9
    oe_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(tdo_oe) |-> (ir_shift || dr_shift));

endmodule

bind jtag_insn_sel jtsel_chk #(.N_OUT(N_OUT)) u_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tap_reset  (tap_reset),
    .ir_capture (ir_capture),
    .ir_shift   (ir_shift),
    .ir_update  (ir_update),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .ir_q       (ir_q),
    .ir_so      (ir_so),
    .byp_q      (byp_q),
    .bsr_upd    (bsr_upd),
    .pin_out    (pin_out),
    .core_out   (core_out),
    .tdo_oe     (tdo_oe)
);

// File: tb/jtag_insn_sel_tb.sv
`timescale 1ns/1ps
module jtag_insn_sel_tb;

    localparam int          N_OUT  = 4;
    localparam int          N_IN   = 4;
    localparam int          USER_W = 8;
    localparam int          BSR_W  = N_OUT + N_IN;
    localparam logic [31:0] ID     = 32'h4D2A_61C3;
    localparam logic [3:0]  ORST   = 4'b0110;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tap_reset = 1'b0;
    logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
    logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
    logic tdi = 1'b0;
    logic tdo, tdo_oe;
    logic [N_OUT-1:0]  core_out = '0;
    logic [N_OUT-1:0]  pin_out;
    logic [N_IN-1:0]   pin_in = '0;
    logic [N_IN-1:0]   core_in;
    logic [USER_W-1:0] user_status = '0;
    logic [USER_W-1:0] user_ctrl;

    always #2 tck = ~tck;

    jtag_insn_sel #(
        .N_OUT   (N_OUT),
        .N_IN    (N_IN),
        .USER_W  (USER_W),
        .ID_CODE (ID),
        .OUT_RST (ORST)
    ) u_dut (
        .tck         (tck),
        .trst_n      (trst_n),
        .tap_reset   (tap_reset),
        .ir_capture  (ir_capture),
        .ir_shift    (ir_shift),
        .ir_update   (ir_update),
        .dr_capture  (dr_capture),
        .dr_shift    (dr_shift),
        .dr_update   (dr_update),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .core_out    (core_out),
        .pin_out     (pin_out),
        .pin_in      (pin_in),
        .core_in     (core_in),
        .user_status (user_status),
        .user_ctrl   (user_ctrl)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;
    logic [N_OUT-1:0]  upd_m;
    logic [USER_W-1:0] uctl_m;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // inputs move 1 ns after a rising edge; tdo is read 1 ns after a falling edge
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        input bit do_upd, output logic [63:0] dout);
        dout = '0;
        if (is_ir) ir_capture = 1'b1; else dr_capture = 1'b1;
        @(posedge tck); #1;
        ir_capture = 1'b0;
        dr_capture = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (is_ir) ir_shift = 1'b1; else dr_shift = 1'b1;
            tdi = din[i];
            @(negedge tck); #1;
            dout[i] = tdo;
            chk("R9 oe during shift", 64'(tdo_oe), 64'd1);
            @(posedge tck); #1;
            chk("R9 tdo held past rising edge", 64'(tdo), 64'(dout[i]));
        end
        ir_shift = 1'b0;
        dr_shift = 1'b0;
        if (do_upd) begin
            if (is_ir) ir_update = 1'b1; else dr_update = 1'b1;
        end
        @(negedge tck); #1;
        chk("R9 oe idle", 64'(tdo_oe), 64'd0);
        @(posedge tck); #1;
        ir_update = 1'b0;
        dr_update = 1'b0;
    endtask

    task automatic load_ir(input logic [3:0] code);
        logic [63:0] d;
        scan(1'b1, 4, 64'(code), 1'b1, d);
        chk("R1 IR capture pattern", 64'(d[3:0]), 64'h1);
    endtask

    function automatic logic [63:0] dr_expect(input logic [63:0] cap, input int len,
                                              input logic [63:0] din, input int n);
        logic [63:0] e;
        e = '0;
        for (int i = 0; i < n; i++) e[i] = (i < len) ? cap[i] : din[i-len];
        return e;
    endfunction

    // 0 bypass, 1 sample, 2 extest, 3 idcode, 4 user
    function automatic int mode_of(input logic [3:0] c);
        case (c)
            4'b0000: return 2;
            4'b0001: return 1;
            4'b0010: return 3;
            4'b1000: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] d, din, e, cap;
        int len, m;
        upd_m  = ORST;
        uctl_m = '0;
        core_out = 4'h9;
        pin_in = 4'h3;
        user_status = 8'h5C;
        #10;
        @(posedge tck); #1;
        trst_n = 1'b1;

        // reset state
        chk("R2 reset path not driving pins", 64'(pin_out), 64'(core_out));
        chk("R8 user_ctrl reset", 64'(user_ctrl), 64'd0);
        chk("R9 oe at reset", 64'(tdo_oe), 64'd0);

        // IDCODE active after reset
        din = 64'h00A7_1E5B_C0DE_F00D;
        scan(1'b0, 40, din, 1'b0, d);
        chk("R2 idcode after trst", d[39:0], dr_expect(64'(ID | 32'h1), 32, din, 40) & 64'hFF_FFFF_FFFF);
        chk("R2 idcode lsb", 64'(d[0]), 64'd1);

        // EXTEST straight after reset drives reset contents
        load_ir(4'b0000);
        chk("R7 extest after reset drives OUT_RST", 64'(pin_out), 64'(ORST));

        // SAMPLE/PRELOAD
        load_ir(4'b0001);
        chk("R5 sample pins follow core", 64'(pin_out), 64'(core_out));
        din = 64'hC5;
        scan(1'b0, BSR_W, din, 1'b1, d);
        chk("R5 sample capture", d[7:0], 64'({pin_in, core_out}));
        upd_m = din[3:0];
        chk("R5 preload not driven", 64'(pin_out), 64'(core_out));
        core_out = 4'hE; #1;
        chk("R5 pins track core", 64'(pin_out), 64'(core_out));

        // shift EXTEST code without update: nothing changes
        scan(1'b1, 4, 64'h0, 1'b0, d);
        chk("R3 no update keeps SAMPLE", 64'(pin_out), 64'(core_out));

        // enter EXTEST: preload is driven
        load_ir(4'b0000);
        chk("R6 extest drives preload", 64'(pin_out), 64'(upd_m));
        pin_in = 4'hA;
        din = 64'h3B;
        scan(1'b0, BSR_W, din, 1'b1, d);
        chk("R6 extest capture", d[7:0], 64'({pin_in, upd_m}));
        upd_m = din[3:0];
        chk("R6 extest new pattern", 64'(pin_out), 64'(upd_m));

        // sweep every instruction code
        for (int c = 0; c < 16; c++) begin
            core_out    = 4'(c) ^ 4'h5;
            pin_in      = ~4'(c);
            user_status = 8'(c * 37 + 11);
            load_ir(4'(c));
            m = mode_of(4'(c));
            din = 64'hA5C3_96E1_7B2D_4F08 ^ (64'(c) * 64'h0123_4567_89AB_CDEF);
            case (m)
                1: begin cap = 64'({pin_in, core_out}); len = BSR_W; end
                2: begin cap = 64'({pin_in, upd_m});    len = BSR_W; end
                3: begin cap = 64'(ID | 32'h1);         len = 32;    end
                4: begin cap = 64'(user_status);        len = USER_W; end
                default: begin cap = 64'd0;             len = 1;     end
            endcase
            scan(1'b0, 40, din, 1'b1, d);
            e = dr_expect(cap, len, din, 40);
            case (m)
                1: chk("R5 sweep sample scan", d, e);
                2: chk("R6 sweep extest scan", d, e);
                3: chk("R2 sweep idcode scan", d, e);
                4: chk("R8 sweep user scan", d, e);
                default: chk("R4 sweep bypass scan", d, e);
            endcase
            if (m == 1 || m == 2) upd_m = din[32 +: N_OUT];
            if (m == 4) uctl_m = din[32 +: USER_W];
            if (m == 2) chk("R6 sweep pins", 64'(pin_out), 64'(upd_m));
            else        chk("R7 sweep pins not driven", 64'(pin_out), 64'(core_out));
            chk("R8 sweep user_ctrl", 64'(user_ctrl), 64'(uctl_m));
        end

        // controller reset state: IDCODE again, update stage retained
        tap_reset = 1'b1;
        @(posedge tck); #1;
        tap_reset = 1'b0;
        din = 64'h77;
        scan(1'b0, 40, din, 1'b0, d);
        chk("R2 idcode after tap_reset", d, dr_expect(64'(ID | 32'h1), 32, din, 40));
        chk("R2 pins released after tap_reset", 64'(pin_out), 64'(core_out));
        load_ir(4'b0000);
        chk("R7 update stage kept over tap_reset", 64'(pin_out), 64'(upd_m));

        // asynchronous reset mid-run
        trst_n = 1'b0;
        @(posedge tck); #1;
        trst_n = 1'b1;
        upd_m  = ORST;
        uctl_m = '0;
        chk("R8 user_ctrl after trst", 64'(user_ctrl), 64'd0);
        load_ir(4'b0000);
        chk("R7 extest after trst drives OUT_RST", 64'(pin_out), 64'(ORST));

        finish_run();
    end

endmodule